// File: doc/BRIEF.md
# Raster Sync and Pixel Coordinate Generator

This block turns one pixel clock into the timing of an analog video raster. Two counters run inside it. The horizontal counter steps once per pixel clock, and the vertical counter steps once per finished line. Each counter reads zero at the first visible pixel, so during visible time it gives the column or row directly. A line runs in this order: visible pixels, front porch, sync pulse, back porch. The counter then returns to zero. A frame follows the same order in lines.

Parameters set the active size, porch lengths, sync width and sync polarity for each axis. The block outputs horizontal sync, vertical sync, a display-enable flag and the pixel coordinates, all from registers on the same clock edge. An image source uses the coordinates and the enable flag to choose colour values. Two constant control lines are also provided for a video DAC: the blanking control is held inactive and the sync-on-green control is held off. The default parameters give 1920x1200 at 60 Hz, and other modes, such as 640x480 at 60 Hz, are chosen through the parameters.

Top module: `rasterSyncGen`

## Requirements
- R1: The line period is H_ACTIVE+H_FRONT+H_PULSE+H_BACK pixel clocks. Within a line, `hSync` is at its active level for exactly H_PULSE clocks, starting H_ACTIVE+H_FRONT clocks after the first visible pixel.
- R2: While the line is in its visible part, `pixCol` equals the horizontal position (0 for the leftmost pixel, rising by one each clock). During horizontal blanking it holds H_ACTIVE-1, and after reset it reads 0 until the first visible pixel.
- R3: The frame period is V_ACTIVE+V_FRONT+V_PULSE+V_BACK lines. `vSync` is active for exactly V_PULSE whole lines, starting V_ACTIVE+V_FRONT lines after the top row. `pixRow` equals the line number during visible lines and holds V_ACTIVE-1 during vertical blanking.
- R4: `dispEn` is 1 exactly when both the horizontal and the vertical position are in their visible parts. A frame therefore contains H_ACTIVE*V_ACTIVE enabled clocks.
- R5: The active level of `hSync` is 1 when H_SYNC_POS=1 and 0 when H_SYNC_POS=0. `vSync` is set the same way by V_SYNC_POS. Outside its pulse, each sync sits at the opposite level.
- R6: A low level on `rstN` at once, without waiting for a clock, drives `dispEn` to 0, `pixCol` and `pixRow` to 0 and both syncs to their inactive levels. After release, the first clocked position is column 0, row 0.
- R7: `dacBlankCtl` is always 1 and `dacGreenSyncCtl` is always 0.
- R8: The sync, enable and coordinate outputs come from registers clocked on the same edge. In any cycle they all describe the same raster position.
- R9: With default parameters the block produces 1920x1200 timing: a line of 2592 clocks with a 208-clock negative horizontal pulse, 1242 lines per frame, and a positive vertical pulse. Setting the parameters to 640/16/96/48 and 480/10/2/33 with both polarities negative gives an 800-clock line with a 96-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Pixel clock of the selected mode |
| rstN | input | 1 | Asynchronous reset, active low |
| hSync | output | 1 | Horizontal sync, polarity set by H_SYNC_POS |
| vSync | output | 1 | Vertical sync, polarity set by V_SYNC_POS |
| dispEn | output | 1 | 1 during visible pixels, 0 during blanking |
| pixRow | output | V_W | Row coordinate, 0 = top row |
| pixCol | output | H_W | Column coordinate, 0 = leftmost column |
| dacBlankCtl | output | 1 | DAC blanking control, held at 1 |
| dacGreenSyncCtl | output | 1 | DAC sync-on-green control, held at 0 |

## Verification
The bench follows every position of several small raster shapes, one with mixed sync polarities and one with both positive. It checks each output against a position model worked out from the counter arithmetic. Off-by-one wraps are caught because the line and frame periods are measured between sync leading edges: a counter that wraps one state early or late changes the measured period and moves every later position. A polarity parameter applied to the wrong axis, or ignored, flips the inactive sync level that the bench samples during reset. Coordinates that are not held at the last visible value during blanking, or an enable built from only one axis, change the per-cycle column and row values and the enabled-clock count per frame. A reset sampled on the clock instead of at once leaves a nonzero row visible in the half cycle after reset is asserted.

// File: rtl/rasterSyncPkg.sv
package rasterSyncPkg;

  // Position decode sent from the control to the output registers
  typedef struct packed {
    logic hVisible;
    logic vVisible;
    logic hPulse;
    logic vPulse;
  } rasterStrobes_t;

endpackage

// File: rtl/rasterAxis.sv
module rasterAxis #(
  parameter int VISIBLE = 8,
  parameter int FRONT   = 2,
  parameter int PULSE   = 3,
  parameter int BACK    = 4,
  parameter int W       = $clog2(VISIBLE + FRONT + PULSE + BACK)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  output logic [W-1:0] pos,
  output logic         wrap,
  output logic         visible,
  output logic         inPulse
);

  localparam int SPAN        = VISIBLE + FRONT + PULSE + BACK;
  localparam int PULSE_FIRST = VISIBLE + FRONT;
  localparam int PULSE_LAST  = VISIBLE + FRONT + PULSE - 1;

  localparam logic [W-1:0] LAST_POS  = W'(SPAN - 1);
  localparam logic [W-1:0] VIS_LIMIT = W'(VISIBLE);
  localparam logic [W-1:0] P_FIRST   = W'(PULSE_FIRST);
  localparam logic [W-1:0] P_LAST    = W'(PULSE_LAST);

  logic atEnd;

  assign atEnd   = (pos == LAST_POS);
  assign wrap    = step && atEnd;
  assign visible = (pos < VIS_LIMIT);
  assign inPulse = (pos >= P_FIRST) && (pos <= P_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (step) begin
      if (atEnd) pos <= '0;
      else       pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/rasterCtrl.sv
module rasterCtrl
  import rasterSyncPkg::*;
#(
  parameter int H_ACTIVE = 1920,
  parameter int H_FRONT  = 128,
  parameter int H_PULSE  = 208,
  parameter int H_BACK   = 336,
  parameter int V_ACTIVE = 1200,
  parameter int V_FRONT  = 1,
  parameter int V_PULSE  = 3,
  parameter int V_BACK   = 38,
  parameter int H_W      = $clog2(H_ACTIVE + H_FRONT + H_PULSE + H_BACK),
  parameter int V_W      = $clog2(V_ACTIVE + V_FRONT + V_PULSE + V_BACK)
) (
  input  logic           clk,
  input  logic           rstN,
  output logic [H_W-1:0] hPos,
  output logic [V_W-1:0] vPos,
  output rasterStrobes_t strobes
);

  logic lineDone;
  logic frameDone;
  logic hVis, vVis, hPul, vPul;

  rasterAxis #(
    .VISIBLE(H_ACTIVE), .FRONT(H_FRONT), .PULSE(H_PULSE), .BACK(H_BACK), .W(H_W)
  ) u_hAxis (
    .clk(clk), .rstN(rstN), .step(1'b1),
    .pos(hPos), .wrap(lineDone), .visible(hVis), .inPulse(hPul)
  );

  rasterAxis #(
    .VISIBLE(V_ACTIVE), .FRONT(V_FRONT), .PULSE(V_PULSE), .BACK(V_BACK), .W(V_W)
  ) u_vAxis (
    .clk(clk), .rstN(rstN), .step(lineDone),
    .pos(vPos), .wrap(frameDone), .visible(vVis), .inPulse(vPul)
  );

  // The end-of-frame wrap has no consumer; the vertical counter restarts by itself
  logic frameDoneSink;
  assign frameDoneSink = frameDone;

  always_comb begin
    strobes.hVisible = hVis;
    strobes.vVisible = vVis;
    strobes.hPulse   = hPul;
    strobes.vPulse   = vPul;
  end

endmodule

// File: rtl/rasterDatapath.sv
module rasterDatapath
  import rasterSyncPkg::*;
#(
  parameter int H_W        = 12,
  parameter int V_W        = 11,
  parameter bit H_SYNC_POS = 1'b0,
  parameter bit V_SYNC_POS = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [H_W-1:0] hPos,
  input  logic [V_W-1:0] vPos,
  input  rasterStrobes_t strobes,
  output logic           hSyncQ,
  output logic           vSyncQ,
  output logic           dispEnQ,
  output logic [H_W-1:0] colQ,
  output logic [V_W-1:0] rowQ
);

  localparam logic H_IDLE = ~H_SYNC_POS;
  localparam logic V_IDLE = ~V_SYNC_POS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSyncQ  <= H_IDLE;
      vSyncQ  <= V_IDLE;
      dispEnQ <= 1'b0;
      colQ    <= '0;
      rowQ    <= '0;
    end else begin
      hSyncQ  <= strobes.hPulse ? H_SYNC_POS : H_IDLE;
      vSyncQ  <= strobes.vPulse ? V_SYNC_POS : V_IDLE;
      dispEnQ <= strobes.hVisible && strobes.vVisible;
      if (strobes.hVisible) colQ <= hPos;
      if (strobes.vVisible) rowQ <= vPos;
    end
  end

endmodule

// File: rtl/rasterSyncGen.sv
module rasterSyncGen
  import rasterSyncPkg::*;
#(
  parameter int H_ACTIVE   = 1920,
  parameter int H_FRONT    = 128,
  parameter int H_PULSE    = 208,
  parameter int H_BACK     = 336,
  parameter int V_ACTIVE   = 1200,
  parameter int V_FRONT    = 1,
  parameter int V_PULSE    = 3,
  parameter int V_BACK     = 38,
  parameter bit H_SYNC_POS = 1'b0,
  parameter bit V_SYNC_POS = 1'b1,
  parameter int H_W        = $clog2(H_ACTIVE + H_FRONT + H_PULSE + H_BACK),
  parameter int V_W        = $clog2(V_ACTIVE + V_FRONT + V_PULSE + V_BACK)
) (
  input  logic           pixClk,
  input  logic           rstN,
  output logic           hSync,
  output logic           vSync,
  output logic           dispEn,
  output logic [V_W-1:0] pixRow,
  output logic [H_W-1:0] pixCol,
  output logic           dacBlankCtl,
  output logic           dacGreenSyncCtl
);

  logic [H_W-1:0] hPos;
  logic [V_W-1:0] vPos;
  rasterStrobes_t strobes;

  rasterCtrl #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_PULSE(H_PULSE), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_PULSE(V_PULSE), .V_BACK(V_BACK),
    .H_W(H_W), .V_W(V_W)
  ) u_ctrl (
    .clk(pixClk), .rstN(rstN), .hPos(hPos), .vPos(vPos), .strobes(strobes)
  );

  rasterDatapath #(
    .H_W(H_W), .V_W(V_W), .H_SYNC_POS(H_SYNC_POS), .V_SYNC_POS(V_SYNC_POS)
  ) u_dp (
    .clk(pixClk), .rstN(rstN), .hPos(hPos), .vPos(vPos), .strobes(strobes),
    .hSyncQ(hSync), .vSyncQ(vSync), .dispEnQ(dispEn), .colQ(pixCol), .rowQ(pixRow)
  );

  assign dacBlankCtl     = 1'b1;
  assign dacGreenSyncCtl = 1'b0;

endmodule

// File: rtl/rasterSyncGenChk.sv
module rasterSyncGenChk #(
  parameter int H_ACTIVE   = 8,
  parameter int H_PULSE    = 3,
  parameter int H_TOTAL    = 17,
  parameter int V_ACTIVE   = 5,
  parameter int V_PULSE    = 2,
  parameter bit H_SYNC_POS = 1'b0,
  parameter bit V_SYNC_POS = 1'b1,
  parameter int H_W        = 5,
  parameter int V_W        = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           hSync,
  input logic           vSync,
  input logic           dispEn,
  input logic [V_W-1:0] pixRow,
  input logic [H_W-1:0] pixCol,
  input logic           dacBlankCtl,
  input logic           dacGreenSyncCtl
);

  int hRun;
  int vRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hRun <= 0;
      vRun <= 0;
    end else begin
      hRun <= (hSync == H_SYNC_POS) ? hRun + 1 : 0;
      vRun <= (vSync == V_SYNC_POS) ? vRun + 1 : 0;
    end
  end

  assert_dac_const_R7: assert property (@(posedge clk) disable iff (!rstN)
    dacBlankCtl && !dacGreenSyncCtl);

  assert_col_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dispEn && $past(dispEn)) |-> (pixCol == H_W'($past(pixCol) + 1'b1)));

  assert_coord_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    dispEn |-> ((int'(pixCol) < H_ACTIVE) && (int'(pixRow) < V_ACTIVE)));

  assert_en_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispEn) |-> (pixCol == '0));

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dispEn && (pixCol != '0)) |-> $stable(pixRow));

  assert_hpulse_width_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((hSync != H_SYNC_POS) && (hRun != 0)) |-> (hRun == H_PULSE));

  assert_vpulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((vSync != V_SYNC_POS) && (vRun != 0)) |-> (vRun == V_PULSE * H_TOTAL));

endmodule

bind rasterSyncGen rasterSyncGenChk #(
  .H_ACTIVE(H_ACTIVE), .H_PULSE(H_PULSE),
  .H_TOTAL(H_ACTIVE + H_FRONT + H_PULSE + H_BACK),
  .V_ACTIVE(V_ACTIVE), .V_PULSE(V_PULSE),
  .H_SYNC_POS(H_SYNC_POS), .V_SYNC_POS(V_SYNC_POS),
  .H_W(H_W), .V_W(V_W)
) u_chk (
  .clk(pixClk), .rstN(rstN), .hSync(hSync), .vSync(vSync), .dispEn(dispEn),
  .pixRow(pixRow), .pixCol(pixCol), .dacBlankCtl(dacBlankCtl),
  .dacGreenSyncCtl(dacGreenSyncCtl)
);

// File: tb/rasterModeTester.sv
module rasterModeTester #(
  parameter int HA   = 1920,
  parameter int HFP  = 128,
  parameter int HS   = 208,
  parameter int HBP  = 336,
  parameter int VA   = 1200,
  parameter int VFP  = 1,
  parameter int VS   = 3,
  parameter int VBP  = 38,
  parameter bit HPOS = 1'b0,
  parameter bit VPOS = 1'b1,
  parameter bit USE_DEFAULTS = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  output int   nChecks,
  output int   nErrors,
  output logic de,
  output logic [$clog2(VA+VFP+VS+VBP)-1:0] row
);

  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int HW = $clog2(HT);

  logic hs, vs, blk, sog;
  logic [HW-1:0] col;

  if (USE_DEFAULTS) begin : g_def
    rasterSyncGen u_dut (
      .pixClk(clk), .rstN(rstN), .hSync(hs), .vSync(vs), .dispEn(de),
      .pixRow(row), .pixCol(col), .dacBlankCtl(blk), .dacGreenSyncCtl(sog)
    );
  end else begin : g_ovr
    rasterSyncGen #(
      .H_ACTIVE(HA), .H_FRONT(HFP), .H_PULSE(HS), .H_BACK(HBP),
      .V_ACTIVE(VA), .V_FRONT(VFP), .V_PULSE(VS), .V_BACK(VBP),
      .H_SYNC_POS(HPOS), .V_SYNC_POS(VPOS)
    ) u_dut (
      .pixClk(clk), .rstN(rstN), .hSync(hs), .vSync(vs), .dispEn(de),
      .pixRow(row), .pixCol(col), .dacBlankCtl(blk), .dacGreenSyncCtl(sog)
    );
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s in %m: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int k, x, y, lastH, lastV, hRun, vRun, enCnt;
  bit haveH, haveV, prevH, prevV, hAct, vAct, hWin, vWin, vis;

  initial begin
    nChecks = 0; nErrors = 0; k = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        // R6 reset state, R5 idle polarity, R7 constants
        check(de == 1'b0, "R6", "reset dispEn", int'(de), 0);
        check(col == '0, "R6", "reset col", int'(col), 0);
        check(row == '0, "R6", "reset row", int'(row), 0);
        check(hs == !HPOS, "R5", "reset hSync idle", int'(hs), int'(!HPOS));
        check(vs == !VPOS, "R5", "reset vSync idle", int'(vs), int'(!VPOS));
        check(blk && !sog, "R7", "dac control", int'({blk, sog}), 2);
        k = 0; haveH = 0; haveV = 0; prevH = 0; prevV = 0;
        hRun = 0; vRun = 0; enCnt = 0;
      end else begin
        x = k % HT;
        y = (k / HT) % VT;
        vis  = (x < HA) && (y < VA);
        hWin = (x >= HA + HFP) && (x < HA + HFP + HS);
        vWin = (y >= VA + VFP) && (y < VA + VFP + VS);
        check(de == vis, "R4", "dispEn", int'(de), int'(vis));
        check(hs == (hWin ? HPOS : !HPOS), "R5", "hSync level", int'(hs),
              int'(hWin ? HPOS : !HPOS));
        check(vs == (vWin ? VPOS : !VPOS), "R5", "vSync level", int'(vs),
              int'(vWin ? VPOS : !VPOS));
        // R2 column, held at last visible value in blanking; R8 alignment
        check(int'(col) == ((x < HA) ? x : HA - 1), "R2", "column", int'(col),
              (x < HA) ? x : HA - 1);
        // R3 row, held at last visible row in blanking
        check(int'(row) == ((y < VA) ? y : VA - 1), "R3", "row", int'(row),
              (y < VA) ? y : VA - 1);
        check(blk && !sog, "R7", "dac control", int'({blk, sog}), 2);
        if (de) enCnt++;

        hAct = (hs == HPOS);
        if (hAct && !prevH) begin
          if (haveH) check(k - lastH == HT, "R1", "line period", k - lastH, HT);
          lastH = k; haveH = 1; hRun = 0;
        end
        if (hAct) hRun++;
        if (!hAct && prevH) check(hRun == HS, "R1", "hSync width", hRun, HS);
        prevH = hAct;

        vAct = (vs == VPOS);
        if (vAct && !prevV) begin
          if (haveV) check(k - lastV == HT * VT, "R3", "frame period", k - lastV, HT * VT);
          check(enCnt == HA * VA, "R4", "enabled clocks per frame", enCnt, HA * VA);
          enCnt = 0; lastV = k; haveV = 1; vRun = 0;
        end
        if (vAct) vRun++;
        if (!vAct && prevV) check(vRun == VS * HT, "R3", "vSync width", vRun, VS * HT);
        prevV = vAct;
        k++;
      end
    end
  end

endmodule

// File: tb/rasterSyncGen_tb.sv
module rasterSyncGen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int cA, eA, cB, eB, cC, eC, cD, eD;
  int tbChecks = 0;
  int tbErrors = 0;
  bit timedOut = 0;

  logic deA, deB, deC, deD;
  logic [3:0] rowA;
  logic [3:0] rowB;
  logic [9:0] rowC;
  logic [10:0] rowD;

  // small mode, negative horizontal and positive vertical sync
  rasterModeTester #(.HA(8), .HFP(2), .HS(3), .HBP(4), .VA(5), .VFP(1), .VS(2), .VBP(3),
                     .HPOS(1'b0), .VPOS(1'b1)) u_modeA (
    .clk(clk), .rstN(rstN), .nChecks(cA), .nErrors(eA), .de(deA), .row(rowA));

  // small mode, both syncs positive, one-clock back porch
  rasterModeTester #(.HA(6), .HFP(1), .HS(2), .HBP(1), .VA(4), .VFP(2), .VS(1), .VBP(2),
                     .HPOS(1'b1), .VPOS(1'b1)) u_modeB (
    .clk(clk), .rstN(rstN), .nChecks(cB), .nErrors(eB), .de(deB), .row(rowB));

  // R9 640x480 timing, both negative
  rasterModeTester #(.HA(640), .HFP(16), .HS(96), .HBP(48), .VA(480), .VFP(10), .VS(2),
                     .VBP(33), .HPOS(1'b0), .VPOS(1'b0)) u_modeC (
    .clk(clk), .rstN(rstN), .nChecks(cC), .nErrors(eC), .de(deC), .row(rowC));

  // R9 default parameters of the block
  rasterModeTester #(.USE_DEFAULTS(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .nChecks(cD), .nErrors(eD), .de(deD), .row(rowD));

  task automatic tbCheck(input bit ok, input string req, input string what,
                         input int act, input int exp);
    tbChecks++;
    if (!ok) begin
      tbErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        #2 rstN = 1'b1;
        repeat (600) @(negedge clk);
        // mode A is at row 2 of a visible line here
        tbCheck(deA == 1'b1 && rowA != '0, "R6", "precondition de/row", int'(rowA), 2);
        #2 rstN = 1'b0;
        #3;
        // R6 reset acts before any clock edge
        tbCheck(deA == 1'b0, "R6", "async clear dispEn", int'(deA), 0);
        tbCheck(rowA == '0, "R6", "async clear row", int'(rowA), 0);
        repeat (3) @(negedge clk);
        #2 rstN = 1'b1;
        repeat (8200) @(negedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        timedOut = 1;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    tbCheck(cD > 7000 && cC > 7000, "R9", "default and 640 modes exercised", cD, 7000);
    $display("CHECKS %0d ERRORS %0d",
             cA + cB + cC + cD + tbChecks + int'(timedOut),
             eA + eB + eC + eD + tbErrors + int'(timedOut));
    $finish;
  end

endmodule